// File: doc/BRIEF.md
# Extended Golay (24,12) Hard-Decision Decoder

This block takes one 24-bit received word of a systematic extended Golay code and returns the 12 corrected information bits. It can correct any pattern of up to three flipped bits anywhere in the word. Any four-bit error pattern is detected and flagged. Decoding uses the syndrome method in four successive tests. The first test checks whether the syndrome itself is light enough to be the error. The second tests the syndrome against each row of the code matrix. The third and fourth repeat these two tests on the syndrome multiplied by that matrix. The block stops at the first test that identifies the error pattern. If none of the four succeeds, it stops in a failure state.

A decode starts when the synchronous reset is released. The word on `code_i` must stay stable from the reset edge until the result is complete. Every result is ready within five clock edges. Once `done_o` is high, the outputs keep their values until the next reset. The number of the test that succeeded is also reported, which shows where in the word the errors lie.

Top module: `golay24_decoder`

## Requirements
- R1: The word layout is as follows. Data bit j is `code_i[12+j]` and parity bit j is `code_i[j]`. The parity part equals data·M over GF(2), where M is a symmetric 12x12 matrix. For i,j < 11, M[i][j] = bit ((i+j) mod 11) of 11'b01000111011. For i < 11, M[i][11] = M[11][i] = 1, and M[11][11] = 0. An error-free word decodes to its data bits with `fail_o` = 0.
- R2: For every error pattern of weight 1, 2 or 3, `data_o` equals the transmitted data and `fail_o` is 0.
- R3: Let w1 be the number of errors in the data half and w2 the number in the parity half. A correctable pattern resolves as follows: at test 1 when w1 = 0, at test 2 when w1 = 1, at test 3 when w1 ≥ 2 and w2 = 0, and at test 4 otherwise.
- R4: Any weight-4 error pattern ends with `fail_o` = 1, `step_o` = 0, and `data_o` equal to the received upper half, uncorrected.
- R5: Count rising edges starting with the first edge at which `rst` is sampled low. `done_o` rises after edge n+1 for a word resolved at test n, and after edge 5 on failure. It is low before that.
- R6: Once `done_o` is 1, `data_o`, `fail_o`, `step_o` and `done_o` stay unchanged until reset. `fail_o` never falls without a reset.
- R7: While `rst` is high, after a clock edge, `done_o`, `fail_o` and `step_o` read 0 and `data_o` reads 0.
- R8: `step_o` reads 1 to 4 on a successful decode. It reads 0 while the decode is in progress and after a failure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset; releasing it starts a decode |
| code_i | input | 24 | Received word, held stable during a decode |
| data_o | output | 12 | Corrected data bits (raw upper half on failure) |
| fail_o | output | 1 | Uncorrectable word detected; sticky until reset |
| done_o | output | 1 | Result valid and held |
| step_o | output | 3 | Test number (1-4) that located the error, 0 otherwise |

## Verification
The result is due at a fixed edge: edge n+1 after reset release for a word resolved at test n, and edge 5 for a failure. The bench computes that edge from the error pattern alone, using the split of errors between the two halves. It samples `done_o` on the falling edge after each of seven rising edges and records the first edge at which `done_o` is high. It compares that edge with the expected one, and checks the held values again on the following edge. The bench sweeps all single, double and triple error patterns. It also covers a regular subsample of the four-error patterns, computing the codewords with its own encoder.

// File: rtl/golay_pkg.sv
package golay_pkg;

    localparam int unsigned HALF_W = 12;
    localparam int unsigned WORD_W = 2 * HALF_W;
    localparam int unsigned CYC_N  = HALF_W - 1;
    localparam int unsigned WT_W   = $clog2(HALF_W + 1);
    localparam int unsigned IDX_W  = $clog2(HALF_W);
    localparam int unsigned STEP_W = 3;

    // Cyclic seed of the 11x11 core of the symmetric code matrix.
    localparam logic [CYC_N-1:0] CYC_SEED = 11'b01000111011;

    typedef logic [HALF_W-1:0] half_t;
    typedef logic [WT_W-1:0]   wt_t;

    typedef struct packed {
        half_t data;
        half_t par;
    } word_t;

    typedef enum logic [2:0] {
        ST_LOAD,
        ST_T1,
        ST_T2,
        ST_T3,
        ST_T4,
        ST_DONE,
        ST_FAIL
    } state_t;

    // Row i of the symmetric code matrix; column j sits at bit j.
    function automatic half_t mat_row(int unsigned i);
        half_t r;
        for (int unsigned j = 0; j < HALF_W; j++) begin
            if (i == CYC_N && j == CYC_N)
                r[j] = 1'b0;
            else if (i == CYC_N || j == CYC_N)
                r[j] = 1'b1;
            else
                r[j] = CYC_SEED[(i + j) % CYC_N];
        end
        return r;
    endfunction

    // Row vector times the code matrix over GF(2).
    function automatic half_t mat_mul(half_t v);
        half_t acc = '0;
        for (int unsigned i = 0; i < HALF_W; i++)
            if (v[i]) acc ^= mat_row(i);
        return acc;
    endfunction

    function automatic wt_t weight(half_t v);
        wt_t n = '0;
        for (int unsigned i = 0; i < HALF_W; i++)
            n += wt_t'(v[i]);
        return n;
    endfunction

endpackage

// File: rtl/golay_syndrome.sv
module golay_syndrome
    import golay_pkg::*;
(
    input  word_t rx,
    output half_t syn,
    output half_t syn_m
);
    // First syndrome: recomputed parity against received parity.
    assign syn   = mat_mul(rx.data) ^ rx.par;
    // Second syndrome: the matrix is its own inverse, so this moves the
    // error view onto the data half.
    assign syn_m = mat_mul(syn);
endmodule

// File: rtl/golay_row_search.sv
module golay_row_search
    import golay_pkg::*;
#(
    parameter int unsigned MAX_WT = 2
)(
    input  half_t              vec,
    output logic               hit,
    output logic [IDX_W-1:0]   idx
);
    localparam wt_t LIM = wt_t'(MAX_WT);

    logic [HALF_W-1:0] near;

    for (genvar i = 0; i < HALF_W; i++) begin : g_row
        assign near[i] = (weight(vec ^ mat_row(i)) <= LIM);
    end

    // Lowest matching row wins; with at most three errors only one can match.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = HALF_W - 1; i >= 0; i--) begin
            if (near[i]) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/golay24_decoder.sv
module golay24_decoder
    import golay_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] code_i,
    output logic [HALF_W-1:0] data_o,
    output logic              fail_o,
    output logic              done_o,
    output logic [STEP_W-1:0] step_o
);
    localparam wt_t DIRECT_LIM = wt_t'(3);
    localparam int unsigned LAT_MAX = 5;

    state_t            state_q;
    word_t             rx_q;
    half_t             syn_q, synm_q;
    half_t             syn_c, synm_c;
    logic              hit_a, hit_b;
    logic [IDX_W-1:0]  idx_a, idx_b;

    golay_syndrome u_syn (
        .rx    (word_t'(code_i)),
        .syn   (syn_c),
        .syn_m (synm_c)
    );

    golay_row_search #(.MAX_WT(2)) u_search_a (
        .vec (syn_q),
        .hit (hit_a),
        .idx (idx_a)
    );

    golay_row_search #(.MAX_WT(2)) u_search_b (
        .vec (synm_q),
        .hit (hit_b),
        .idx (idx_b)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_LOAD;
            rx_q    <= '0;
            syn_q   <= '0;
            synm_q  <= '0;
            data_o  <= '0;
            fail_o  <= 1'b0;
            done_o  <= 1'b0;
            step_o  <= '0;
        end else begin
            case (state_q)
                ST_LOAD: begin
                    rx_q    <= word_t'(code_i);
                    syn_q   <= syn_c;
                    synm_q  <= synm_c;
                    state_q <= ST_T1;
                end
                ST_T1: begin
                    if (weight(syn_q) <= DIRECT_LIM) begin
                        data_o  <= rx_q.data;
                        step_o  <= STEP_W'(1);
                        done_o  <= 1'b1;
                        state_q <= ST_DONE;
                    end else begin
                        state_q <= ST_T2;
                    end
                end
                ST_T2: begin
                    if (hit_a) begin
                        data_o  <= rx_q.data ^ (half_t'(1) << idx_a);
                        step_o  <= STEP_W'(2);
                        done_o  <= 1'b1;
                        state_q <= ST_DONE;
                    end else begin
                        state_q <= ST_T3;
                    end
                end
                ST_T3: begin
                    if (weight(synm_q) <= DIRECT_LIM) begin
                        data_o  <= rx_q.data ^ synm_q;
                        step_o  <= STEP_W'(3);
                        done_o  <= 1'b1;
                        state_q <= ST_DONE;
                    end else begin
                        state_q <= ST_T4;
                    end
                end
                ST_T4: begin
                    if (hit_b) begin
                        data_o  <= rx_q.data ^ synm_q ^ mat_row(32'(idx_b));
                        step_o  <= STEP_W'(4);
                        state_q <= ST_DONE;
                    end else begin
                        data_o  <= rx_q.data;
                        fail_o  <= 1'b1;
                        state_q <= ST_FAIL;
                    end
                    done_o <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // ---------------- assertions ----------------
    logic [2:0] since_rst_q;
    always_ff @(posedge clk) begin
        if (rst)                       since_rst_q <= '0;
        else if (since_rst_q != 3'd7)  since_rst_q <= since_rst_q + 3'd1;
    end

    assert_latency_R5: assert property (@(posedge clk) disable iff (rst)
        (since_rst_q >= 3'(LAT_MAX)) |-> done_o);

    assert_early_R5: assert property (@(posedge clk) disable iff (rst)
        (since_rst_q < 3'd2) |-> !done_o);

    assert_result_hold_R6: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (done_o && $stable(data_o) && $stable(fail_o) && $stable(step_o)));

    assert_fail_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        fail_o |=> fail_o);

    assert_fail_no_step_R4: assert property (@(posedge clk) disable iff (rst)
        fail_o |-> (done_o && step_o == '0));

    assert_step_range_R8: assert property (@(posedge clk) disable iff (rst)
        (done_o && !fail_o) |-> (step_o >= STEP_W'(1) && step_o <= STEP_W'(4)));

    assert_busy_step_R8: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> (step_o == '0 && !fail_o));
endmodule

// File: tb/golay24_decoder_tb.sv
module golay24_decoder_tb;
    localparam time CLK_P = 10ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:0] code_i = '0;
    logic [11:0] data_o;
    logic        fail_o, done_o;
    logic [2:0]  step_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_P / 2) clk = ~clk;

    golay24_decoder u_dut (
        .clk(clk), .rst(rst), .code_i(code_i),
        .data_o(data_o), .fail_o(fail_o), .done_o(done_o), .step_o(step_o)
    );

    function automatic bit mat_bit(int i, int j);
        logic [10:0] seed = 11'b01000111011;
        if (i == 11 && j == 11) return 1'b0;
        if (i == 11 || j == 11) return 1'b1;
        return seed[(i + j) % 11];
    endfunction

    function automatic logic [23:0] encode(logic [11:0] d);
        logic [11:0] p;
        for (int j = 0; j < 12; j++) begin
            p[j] = 1'b0;
            for (int i = 0; i < 12; i++) p[j] = p[j] ^ (d[i] & mat_bit(i, j));
        end
        return {d, p};
    endfunction

    function automatic int ones(logic [11:0] v);
        int n = 0;
        for (int i = 0; i < 12; i++) n += int'(v[i]);
        return n;
    endfunction

    task automatic check(bit ok, string req, string what, int got, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    // Run one decode of the codeword of d with error pattern e.
    task automatic trial(logic [11:0] d, logic [23:0] e, bit chk_reset);
        logic [23:0] rx = encode(d) ^ e;
        int w1 = ones(e[23:12]);
        int w2 = ones(e[11:0]);
        bit exp_fail = (w1 + w2) >= 4;
        int exp_step;
        int exp_edge;
        int first = 0;
        logic [11:0] d6;
        logic f6;
        logic [2:0] s6;
        if (exp_fail)        exp_step = 0;
        else if (w1 == 0)    exp_step = 1;
        else if (w1 == 1)    exp_step = 2;
        else if (w2 == 0)    exp_step = 3;
        else                 exp_step = 4;
        exp_edge = exp_fail ? 5 : exp_step + 1;

        @(negedge clk);
        rst = 1'b1;
        code_i = rx;
        @(posedge clk);
        @(negedge clk);
        if (chk_reset) begin
            // R7: reset state
            check(done_o == 0 && fail_o == 0 && step_o == 0 && data_o == 0,
                  "R7", "reset outputs", {done_o, fail_o, step_o, data_o}, 0);
        end
        rst = 1'b0;
        for (int k = 1; k <= 7; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (done_o && first == 0) first = k;
            if (k == 6) begin d6 = data_o; f6 = fail_o; s6 = step_o; end
        end
        // R5: done appears at the expected edge
        check(first == exp_edge, "R5", "done edge", first, exp_edge);
        if (exp_fail) begin
            // R4: uncorrectable detection, raw data passed through
            check(fail_o == 1'b1, "R4", "fail flag", int'(fail_o), 1);
            check(data_o == rx[23:12], "R4", "raw data", int'(data_o), int'(rx[23:12]));
            check(step_o == 3'd0, "R4", "step on fail", int'(step_o), 0);
        end else begin
            // R1/R2: corrected data, no failure
            check(data_o == d, (w1 + w2 == 0) ? "R1" : "R2", "data", int'(data_o), int'(d));
            check(fail_o == 1'b0, "R2", "fail flag", int'(fail_o), 0);
            // R3/R8: resolving test
            check(int'(step_o) == exp_step, "R3", "step", int'(step_o), exp_step);
        end
        // R6: held values
        check(data_o == d6 && fail_o == f6 && step_o == s6 && done_o,
              "R6", "hold", {done_o, fail_o, step_o, data_o}, {1'b1, f6, s6, d6});
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [11:0] dws [3] = '{12'h000, 12'hA5C, 12'hFFF};
        int n4 = 0;
        // R1: clean words
        for (int i = 0; i < 16; i++)
            trial(12'(i * 273 + 17), 24'h0, i == 0);
        // R2/R3: single and double errors
        for (int w = 0; w < 3; w++)
            for (int a = 0; a < 24; a++) begin
                trial(dws[w], 24'(1) << a, 1'b0);
                for (int b = a + 1; b < 24; b++)
                    trial(dws[w], (24'(1) << a) | (24'(1) << b), 1'b0);
            end
        // R2/R3: all triple errors on two data words
        for (int w = 1; w < 3; w++)
            for (int a = 0; a < 24; a++)
                for (int b = a + 1; b < 24; b++)
                    for (int c = b + 1; c < 24; c++)
                        trial(dws[w] ^ 12'(a * 5 + c), (24'(1) << a) | (24'(1) << b) | (24'(1) << c), 1'b0);
        // R4: subsample of four-error patterns
        for (int a = 0; a < 24; a++)
            for (int b = a + 1; b < 24; b++)
                for (int c = b + 1; c < 24; c++)
                    for (int e = c + 1; e < 24; e++) begin
                        n4++;
                        if (n4 % 13 == 0)
                            trial(12'(n4 * 7), (24'(1) << a) | (24'(1) << b) | (24'(1) << c) | (24'(1) << e), 1'b0);
                    end
        // R7: reset state again after activity
        trial(12'h5A3, 24'h000100, 1'b1);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule